// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block drives a 12-bit serial analog-to-digital converter that powers itself down between conversions. It raises a chip-select line to wake the converter and to start a conversion. After the wake-up wait it toggles a serial clock sixteen times and shifts in the bit that the converter drives after each falling clock edge. From the 16-bit frame it checks the four zero bits that lead the frame and keeps the twelve sample bits. The sample goes into an output register and is announced with a one-cycle strobe.

A sample-rate timer sets how often conversions begin. The rate input gives the sample period in system clock cycles. Any period shorter than wake-up time plus frame time plus the minimum power-down time is lengthened to that minimum. The serial clock divider, the wake-up wait and the power-down gap all come from parameters given in MHz and ns. Elaboration rejects any setting that would exceed the converter's clock limits or leave too little time for a data bit to settle before it is sampled. At the default 100 MHz system clock the serial clock divides by 10 (5 cycles low, 5 high). The wake-up wait is 100 cycles, the power-down gap is 740 cycles and the shortest sample period is 1000 cycles.

Top module: `adc_serial_reader`

## Requirements
- R1: While reset is applied and after it is released, `cs_o` is 0, `sclk_o` is 1, `sample_valid_o` and `frame_err_o` are 0 and `sample_o` is 0. No conversion starts within the first 740 cycles after reset.
- R2: Each conversion holds `cs_o` at 1 for exactly 260 cycles. `sclk_o` stays 1 for the first 100 of them. Then come exactly 16 serial clock periods, each 5 cycles low followed by 5 cycles high, starting with a falling edge.
- R3: `sclk_o` is 1 in every cycle in which `cs_o` is 0.
- R4: `sdata_i` is sampled at each rising edge of `sclk_o` within a conversion and is ignored at all other times. The 16 samples form a frame, first bit most significant. Frame bits 15..12 are the leading zeros and bits 11..0 are the sample, which appears on `sample_o`.
- R5: A good frame loads the output register and pulses `sample_valid_o` for exactly one cycle, with `sample_o` already carrying the new value. This happens only when the register is empty or `sample_ready_i` is 1 in that cycle. A full register is emptied in any cycle in which `sample_ready_i` is 1.
- R6: If a good frame arrives while the register is full and `sample_ready_i` is 0, the frame is discarded. `sample_o` keeps its value and no strobe is given.
- R7: If any of frame bits 15..12 is 1, `frame_err_o` pulses for one cycle, `sample_valid_o` stays 0 and `sample_o` is unchanged.
- R8: While `enable_i` stays 1, successive rising edges of `cs_o` are max(`rate_i`, 1000) cycles apart.
- R9: `cs_o` stays 0 for at least 740 cycles between any two conversions.
- R10: While `enable_i` is 0 no new conversion starts, but a conversion already running finishes and delivers its sample. When `enable_i` returns to 1 after both timers have run out, `cs_o` rises at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows new conversions to start |
| rate_i | input | RATE_W (16) | Requested sample period in system clock cycles |
| sdata_i | input | 1 | Serial data from the converter |
| sample_ready_i | input | 1 | Consumer accepts the held sample |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| cs_o | output | 1 | Chip-select; its rising edge wakes the converter and starts a conversion |
| sample_o | output | DATA_W (12) | Held sample word |
| sample_valid_o | output | 1 | One-cycle strobe when a new sample is loaded |
| frame_err_o | output | 1 | One-cycle strobe when the leading bits of a frame are not all zero |

## Verification
The embedded properties check the following on every cycle: the serial clock idles high outside chip-select, the serial clock never falls in the first cycle of chip-select, and each capture strobe is followed by a rising serial clock edge. They also check that a full, unaccepted register holds its value, that the valid strobe and the error strobe never coincide, that every start is taken up by the sequencer, and that the low time of chip-select is never shorter than the power-down minimum. The bench scenarios show the remaining behaviour: the exact frame length and clock phases, which bit lands where in the sample, sample periods across rate settings below and above the minimum, frames dropped while the register is full, each leading bit set alone, and a stop and restart through the enable input.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [1:0] {
      PH_SLEEP = 2'd0,
      PH_WAKE  = 2'd1,
      PH_SHIFT = 2'd2
   } conv_phase_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/adc_rd_pace.sv
module adc_rd_pace #(
   parameter int RATE_W     = 16,
   parameter int MIN_PERIOD = 1000,
   parameter int PWRDN_CYC  = 740
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic              busy_i,
   output logic              start_o
);

   localparam int PD_W = $clog2(PWRDN_CYC + 1);
   localparam logic [RATE_W-1:0] MIN_P   = RATE_W'(MIN_PERIOD);
   localparam logic [RATE_W-1:0] PER_TOP = {RATE_W{1'b1}};
   localparam logic [PD_W-1:0]   PD_LAST = PD_W'(PWRDN_CYC - 1);

   logic [RATE_W-1:0] per_q;
   logic [PD_W-1:0]   pd_q;
   logic [RATE_W-1:0] eff_period;
   logic              per_done;
   logic              pd_done;

   // a requested period below the minimum is stretched to the minimum
   assign eff_period = (rate_i < MIN_P) ? MIN_P : rate_i;
   assign per_done   = (per_q >= (eff_period - 1'b1));
   assign pd_done    = (pd_q >= PD_LAST);
   assign start_o    = enable_i && !busy_i && per_done && pd_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= '0;
         pd_q  <= '0;
      end else begin
         if (start_o)
            per_q <= '0;
         else if (per_q != PER_TOP)
            per_q <= per_q + 1'b1;

         if (busy_i)
            pd_q <= '0;
         else if (!pd_done)
            pd_q <= pd_q + 1'b1;
      end
   end

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) start_o |=> busy_i) else $error("start not taken up"); // R8

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
   import adc_rd_pkg::*;
#(
   parameter int DIV        = 10,
   parameter int HALF_LO    = 5,
   parameter int PWRUP_CYC  = 100,
   parameter int FRAME_BITS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic cs_o,
   output logic sclk_o,
   output logic take_o,
   output logic last_o
);

   localparam int WC_W = $clog2(PWRUP_CYC + 1);
   localparam int PH_W = $clog2(DIV + 1);
   localparam int BN_W = $clog2(FRAME_BITS + 1);

   conv_phase_e     st_q, st_n;
   logic [WC_W-1:0] wc_q, wc_n;
   logic [PH_W-1:0] ph_q, ph_n;
   logic [BN_W-1:0] bn_q, bn_n;
   logic            cs_q, sclk_q, sclk_n;

   always_comb begin
      st_n = st_q;
      wc_n = wc_q;
      ph_n = ph_q;
      bn_n = bn_q;
      case (st_q)
         PH_SLEEP: begin
            if (start_i) begin
               st_n = PH_WAKE;
               wc_n = '0;
            end
         end
         PH_WAKE: begin
            if (wc_q == WC_W'(PWRUP_CYC - 1)) begin
               st_n = PH_SHIFT;
               ph_n = '0;
               bn_n = '0;
            end else begin
               wc_n = wc_q + 1'b1;
            end
         end
         PH_SHIFT: begin
            if (ph_q == PH_W'(DIV - 1)) begin
               ph_n = '0;
               if (bn_q == BN_W'(FRAME_BITS - 1))
                  st_n = PH_SLEEP;
               else
                  bn_n = bn_q + 1'b1;
            end else begin
               ph_n = ph_q + 1'b1;
            end
         end
         default: st_n = PH_SLEEP;
      endcase
      // low half first, so every period opens with a falling edge
      sclk_n = (st_n == PH_SHIFT) ? (ph_n >= PH_W'(HALF_LO)) : 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PH_SLEEP;
         wc_q   <= '0;
         ph_q   <= '0;
         bn_q   <= '0;
         cs_q   <= 1'b0;
         sclk_q <= 1'b1;
      end else begin
         st_q   <= st_n;
         wc_q   <= wc_n;
         ph_q   <= ph_n;
         bn_q   <= bn_n;
         cs_q   <= (st_n != PH_SLEEP);
         sclk_q <= sclk_n;
      end
   end

   // the edge that raises the serial clock is the sampling edge
   assign take_o = (st_q == PH_SHIFT) && (ph_q == PH_W'(HALF_LO - 1));
   assign last_o = (bn_q == BN_W'(FRAME_BITS - 1));
   assign cs_o   = cs_q;
   assign sclk_o = sclk_q;

   AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !cs_q |-> sclk_q) else $error("serial clock low outside frame"); // R3
   AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk_q) |-> $past(cs_q)) else $error("falling edge without setup"); // R2
   AST_TAKE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) take_o |=> (sclk_q && !$past(sclk_q))) else $error("capture off the rising edge"); // R4

endmodule

// File: rtl/adc_rd_frame.sv
module adc_rd_frame #(
   parameter int LEAD_W     = 4,
   parameter int DATA_W     = 12,
   parameter bit CHECK_LEAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic              last_i,
   input  logic              sdata_i,
   output logic              done_o,
   output logic              bad_o,
   output logic [DATA_W-1:0] word_o
);

   localparam int FRAME_W = LEAD_W + DATA_W;

   logic [FRAME_W-1:0] sr_q;
   logic [LEAD_W-1:0]  lead;
   logic               done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         done_q <= 1'b0;
      end else begin
         if (take_i)
            sr_q <= {sr_q[FRAME_W-2:0], sdata_i};
         done_q <= take_i && last_i;
      end
   end

   assign lead   = sr_q[FRAME_W-1 -: LEAD_W];
   assign word_o = sr_q[DATA_W-1:0];
   assign done_o = done_q;

   generate
      if (CHECK_LEAD) begin : g_lead_chk
         assign bad_o = |lead;
      end else begin : g_lead_skip
         assign bad_o = 1'b0;
      end
   endgenerate

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q) else $error("frame done held"); // R4

endmodule

// File: rtl/adc_rd_hold.sv
module adc_rd_hold #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              bad_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic              ready_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              err_o
);

   logic [DATA_W-1:0] data_q;
   logic              full_q;
   logic              valid_q;
   logic              err_q;
   logic              room;
   logic              take_new;

   assign room     = !full_q || ready_i;
   assign take_new = load_i && !bad_i && room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         full_q  <= 1'b0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (take_new)
            data_q <= word_i;
         if (take_new)
            full_q <= 1'b1;
         else if (ready_i)
            full_q <= 1'b0;
         valid_q <= take_new;
         err_q   <= load_i && bad_i;
      end
   end

   assign data_o  = data_q;
   assign valid_o = valid_q;
   assign err_o   = err_q;

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (full_q && !ready_i) |=> $stable(data_q)) else $error("held sample overwritten"); // R6
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) valid_q |=> !valid_q) else $error("valid longer than one cycle"); // R5
   AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) err_q |-> !valid_q) else $error("error frame marked valid"); // R7

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
   parameter int CLK_MHZ      = 100,
   parameter int SCLK_MAX_KHZ = 10000,
   parameter int ACCESS_NS    = 40,
   parameter int PWRUP_NS     = 1000,
   parameter int PWRDN_NS     = 7400,
   parameter int RATE_W       = 16,
   parameter int DATA_W       = 12,
   parameter int LEAD_W       = 4,
   parameter bit CHECK_LEAD   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic              sdata_i,
   input  logic              sample_ready_i,
   output logic              sclk_o,
   output logic              cs_o,
   output logic [DATA_W-1:0] sample_o,
   output logic              sample_valid_o,
   output logic              frame_err_o
);

   localparam int SCLK_DIV   = adc_rd_pkg::ceil_div(CLK_MHZ * 1000, SCLK_MAX_KHZ);
   localparam int HALF_LO    = SCLK_DIV / 2;
   localparam int PWRUP_CYC  = adc_rd_pkg::ceil_div(PWRUP_NS * CLK_MHZ, 1000);
   localparam int PWRDN_CYC  = adc_rd_pkg::ceil_div(PWRDN_NS * CLK_MHZ, 1000);
   localparam int FRAME_W    = LEAD_W + DATA_W;
   localparam int FRAME_CYC  = PWRUP_CYC + FRAME_W * SCLK_DIV;
   localparam int MIN_PERIOD = FRAME_CYC + PWRDN_CYC;
   localparam int GAP_W      = $clog2(PWRDN_CYC + 1);

   // elaboration-time limits on the derived timing
   if (HALF_LO * 1000 <= ACCESS_NS * CLK_MHZ) begin : g_bad_access
      $error("serial clock half period does not exceed data access time");
   end
   if (HALF_LO * 10 < SCLK_DIV * 4) begin : g_bad_duty
      $error("serial clock phase below 40 percent");
   end
   if (SCLK_DIV > CLK_MHZ * 100) begin : g_bad_slow
      $error("serial clock below 10 kHz");
   end
   if (MIN_PERIOD >= (1 << RATE_W)) begin : g_bad_rate
      $error("rate counter too narrow for the minimum period");
   end
   if (PWRUP_CYC < 1) begin : g_bad_wake
      $error("wake-up wait must be at least one cycle");
   end

   logic              start;
   logic              cs_int;
   logic              take;
   logic              last;
   logic              done;
   logic              bad;
   logic [DATA_W-1:0] word;

   adc_rd_pace #(
      .RATE_W     (RATE_W),
      .MIN_PERIOD (MIN_PERIOD),
      .PWRDN_CYC  (PWRDN_CYC)
   ) pace_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (enable_i),
      .rate_i   (rate_i),
      .busy_i   (cs_int),
      .start_o  (start)
   );

   adc_rd_seq #(
      .DIV        (SCLK_DIV),
      .HALF_LO    (HALF_LO),
      .PWRUP_CYC  (PWRUP_CYC),
      .FRAME_BITS (FRAME_W)
   ) seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .cs_o    (cs_int),
      .sclk_o  (sclk_o),
      .take_o  (take),
      .last_o  (last)
   );

   adc_rd_frame #(
      .LEAD_W     (LEAD_W),
      .DATA_W     (DATA_W),
      .CHECK_LEAD (CHECK_LEAD)
   ) frame_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .last_i  (last),
      .sdata_i (sdata_i),
      .done_o  (done),
      .bad_o   (bad),
      .word_o  (word)
   );

   adc_rd_hold #(
      .DATA_W (DATA_W)
   ) hold_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (done),
      .bad_i   (bad),
      .word_i  (word),
      .ready_i (sample_ready_i),
      .data_o  (sample_o),
      .valid_o (sample_valid_o),
      .err_o   (frame_err_o)
   );

   assign cs_o = cs_int;

   // independent gap counter for the power-down check
   logic [GAP_W-1:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= '0;
      else if (cs_int)
         gap_q <= '0;
      else if (gap_q != GAP_W'(PWRDN_CYC))
         gap_q <= gap_q + 1'b1;
   end

   AST_PWRDN_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_int) |-> (gap_q == GAP_W'(PWRDN_CYC))) else $error("power-down gap too short"); // R9

endmodule

// File: tb/adc_serial_reader_tb.sv
module adc_serial_reader_tb_top;

   localparam int DIV    = 10;
   localparam int LO     = DIV / 2;
   localparam int HI     = DIV - LO;
   localparam int PWRUP  = 100;
   localparam int PWRDN  = 740;
   localparam int FRAME  = PWRUP + 16 * DIV;
   localparam int MINP   = FRAME + PWRDN;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [15:0] rate = 16'd0;
   logic        sdata = 1'b1;
   logic        ready = 1'b1;
   logic        sclk, cs, valid, ferr;
   logic [11:0] sample;

   adc_serial_reader dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .enable_i       (enable),
      .rate_i         (rate),
      .sdata_i        (sdata),
      .sample_ready_i (ready),
      .sclk_o         (sclk),
      .cs_o           (cs),
      .sample_o       (sample),
      .sample_valid_o (valid),
      .frame_err_o    (ferr)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // converter model: one bit per falling edge, 33 ns after it
   logic [15:0] next_frame = 16'h0000;
   logic [15:0] cur_frame = 16'h0000;
   int bidx = 0;
   always @(posedge cs) begin
      cur_frame = next_frame;
      bidx = 0;
   end
   always @(negedge sclk) begin
      if (cs) begin
         #33;
         if (bidx < 16) sdata = cur_frame[15 - bidx];
         bidx++;
      end
   end
   always @(negedge cs) begin
      #33;
      sdata = 1'b1;
   end

   // monitor, sampled away from the active edge
   int n_rise = 0, rise_c = 0, fall_c = 0, per_meas = 0, low_meas = 0;
   int high_meas = 0, wake_meas = 0, nfall = 0, phase_bad = 0, run = 0;
   int idle_low = 0, n_valid = 0, n_err = 0, vlong = 0, both = 0;
   logic p_cs = 1'b0, p_sclk = 1'b1, p_valid = 1'b0;
   logic [11:0] last_data = 12'h000;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cs && !p_cs) begin
            if (n_rise > 0) begin
               per_meas = cyc - rise_c;
               low_meas = cyc - fall_c;
            end
            rise_c = cyc;
            n_rise++;
            nfall = 0;
            phase_bad = 0;
         end
         if (!cs && p_cs) begin
            high_meas = cyc - rise_c;
            fall_c = cyc;
         end
         if (!cs && !sclk) idle_low++;
         if (cs && p_cs && (sclk != p_sclk)) begin
            if (!sclk) begin
               nfall++;
               if (nfall == 1) wake_meas = cyc - rise_c;
               else if (run != HI) phase_bad++;
            end else if (run != LO) phase_bad++;
         end
         if (sclk != p_sclk) run = 1; else run++;
         if (valid) begin
            n_valid++;
            last_data = sample;
            if (p_valid) vlong++;
         end
         if (ferr) begin
            n_err++;
            if (valid) both++;
         end
         p_cs = cs;
         p_sclk = sclk;
         p_valid = valid;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic conv(input logic [15:0] fr);
      next_frame = fr;
      @(posedge cs);
      @(negedge cs);
      repeat (3) @(negedge clk);
      #1;
   endtask

   function automatic logic [11:0] pat(input int k);
      case (k)
         0: return 12'h000;
         1: return 12'hFFF;
         2: return 12'h800;
         3: return 12'h001;
         4: return 12'hAAA;
         5: return 12'h555;
         default: return 12'((k * 1237 + 91) & 12'hFFF);
      endcase
   endfunction

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got %0d expected %0d cycles", 150000, 0);
         summary();
      end
   end

   initial begin
      logic [11:0] hold_exp;
      int v0, e0, r0, ec;
      // R1: reset state
      repeat (4) @(negedge clk);
      chk(cs == 1'b0 && sclk == 1'b1, "R1", {cs, sclk}, 1);
      chk(valid == 1'b0 && ferr == 1'b0 && sample == 12'h000, "R1", {valid, ferr, sample}, 0);
      enable = 1'b1;
      rst_n = 1'b1;
      repeat (700) @(negedge clk);
      #1;
      chk(n_rise == 0, "R1", n_rise, 0);
      chk(sclk == 1'b1 && valid == 1'b0, "R1", {sclk, valid}, 2);

      // R2 R4 R5 R8 R9: sweep of sample values at the shortest period
      for (int k = 0; k < 14; k++) begin
         v0 = n_valid;
         conv({4'b0000, pat(k)});
         chk(n_valid == v0 + 1, "R5", n_valid - v0, 1);
         chk(last_data == pat(k) && sample == pat(k), "R4", sample, pat(k));
         chk(high_meas == FRAME, "R2", high_meas, FRAME);
         chk(wake_meas == PWRUP, "R2", wake_meas, PWRUP);
         chk(nfall == 16, "R2", nfall, 16);
         chk(phase_bad == 0, "R2", phase_bad, 0);
         if (k > 0) begin
            chk(per_meas == MINP, "R8", per_meas, MINP);
            chk(low_meas >= PWRDN, "R9", low_meas, PWRDN);
         end
      end

      // R6: register full, consumer not ready
      ready = 1'b0;
      v0 = n_valid;
      conv({4'b0000, 12'h3A5});
      hold_exp = 12'h3A5;
      chk(n_valid == v0 + 1 && sample == hold_exp, "R5", sample, hold_exp);
      conv({4'b0000, 12'hC3C});
      chk(n_valid == v0 + 1, "R6", n_valid - v0, 1);
      chk(sample == hold_exp, "R6", sample, hold_exp);
      @(negedge clk) ready = 1'b1;
      @(negedge clk) ready = 1'b0;
      conv({4'b0000, 12'h5C3});
      chk(n_valid == v0 + 2 && sample == 12'h5C3, "R5", sample, 12'h5C3);
      ready = 1'b1;
      hold_exp = 12'h5C3;

      // R7: each leading bit set alone
      for (int j = 0; j < 4; j++) begin
         v0 = n_valid;
         e0 = n_err;
         conv({4'(1 << j), 12'(12'h3C0 + j)});
         chk(n_err == e0 + 1, "R7", n_err - e0, 1);
         chk(n_valid == v0, "R7", n_valid - v0, 0);
         chk(sample == hold_exp, "R7", sample, hold_exp);
      end

      // R8 R9: rate settings around the minimum
      begin
         int rates [5] = '{1500, 1234, 999, 1000, 1001};
         foreach (rates[i]) begin
            rate = 16'(rates[i]);
            conv({4'b0000, 12'(i * 97)});
            chk(per_meas == ((rates[i] > MINP) ? rates[i] : MINP), "R8", per_meas,
                (rates[i] > MINP) ? rates[i] : MINP);
            chk(low_meas >= PWRDN, "R9", low_meas, PWRDN);
            chk(sample == 12'(i * 97), "R4", sample, i * 97);
         end
      end

      // R10: stop mid-frame, then restart
      v0 = n_valid;
      next_frame = {4'b0000, 12'h2D7};
      @(posedge cs);
      @(negedge clk) enable = 1'b0;
      @(negedge cs);
      repeat (3) @(negedge clk);
      #1;
      chk(n_valid == v0 + 1 && sample == 12'h2D7, "R10", sample, 12'h2D7);
      r0 = n_rise;
      repeat (2500) @(negedge clk);
      #1;
      chk(n_rise == r0, "R10", n_rise - r0, 0);
      @(negedge clk);
      enable = 1'b1;
      ec = cyc;
      @(posedge cs);
      @(negedge clk);
      #1;
      chk(rise_c - ec == 1, "R10", rise_c - ec, 1);
      @(negedge cs);
      repeat (3) @(negedge clk);
      #1;

      // whole-run observations
      chk(idle_low == 0, "R3", idle_low, 0);
      chk(vlong == 0, "R5", vlong, 0);
      chk(both == 0, "R7", both, 0);

      if (!finished) begin
         finished = 1'b1;
         summary();
      end
   end

endmodule